// File: doc/BRIEF.md
# Serial Quad DAC Register Front End

This block is the digital side of a four-channel, 8-bit voltage-output converter. A host sends command words over a three-wire serial port: a serial clock, a data line and a load strobe. Each word picks one channel, sets its gain-range bit and gives its 8-bit code. A separate active-low commit pin controls a two-stage register bank, so the host can change one channel at a time or stage new values for several channels and apply them all together.

All four pins are asynchronous to the block. Each one passes through a two-flop synchroniser running on a faster system clock, and edges are detected after the synchroniser. Every channel has an input latch and an output latch. Each latch holds a code and a range bit. The output latches drive the converter codes and the gain-select flags. The analogue path is outside this block. It produces `Vref * code / 256 * (1 + range)`.

Top module: `qdac_frontend`

## Requirements
- R1: While reset is asserted, and after it is released, every channel's output code and range flag read zero until a command updates them.
- R2: A command word is 11 bits long and is sent most significant bit first. Its bits, in order, are channel address [10:9], range bit [8] and code [7:0]. Address 0 selects channel 0 (`dac_code_o[7:0]`), 1 selects channel 1, 2 selects channel 2 and 3 selects channel 3 (`dac_code_o[31:24]`).
- R3: A data bit is captured only on a falling edge of the serial clock while the load pin is high. Serial clock edges while load is low leave the stored word unchanged.
- R4: Any number of bits may be shifted in. Only the 11 most recently captured bits form the word that is latched.
- R5: While the commit pin is low, a falling edge on the load pin updates the addressed channel's output code and range flag. The other channels do not change.
- R6: While the commit pin is high, a load falling edge changes only the input latch, and the outputs hold. A later falling edge of the commit pin copies all four input latches to the outputs at once.
- R7: The range bit of the word appears on the addressed channel's `dac_range_o` bit, together with its code. A value of 1 selects gain x2 and 0 selects gain x1.
- R8: If the load and commit falling edges are seen in the same system cycle, the addressed channel's output takes the new word. The other channels take their input-latch values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System clock, faster than the serial pins |
| sys_rst_ni | input | 1 | Active-low reset; clears both latch stages |
| ser_clk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_load_i | input | 1 | High while shifting; its falling edge latches the word |
| commit_ni | input | 1 | Low: outputs follow the input latches; its falling edge copies all channels |
| dac_code_o | output | 32 | Four 8-bit converter codes; channel n is at bits [8n+7:8n] |
| dac_range_o | output | 4 | Gain-range flag of each channel (1 = x2) |

## Verification
A pin change made before system edge k passes through two synchroniser flops and one edge-history flop. The registered result is therefore due at edge k+2, the third rising edge counted from k. Output latches react to a load or commit edge on that same edge. The bench drives pins on falling system edges and waits at least six cycles before it compares outputs on a falling edge. Between serial-clock transitions it leaves three cycles, so each edge is detected while data and load are stable. Every check falls well after the three-edge latency and before the next stimulus.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    parameter int NCH_DEF = 4;
    parameter int DW_DEF  = 8;

    localparam int PIN_SCLK   = 0;
    localparam int PIN_SDATA  = 1;
    localparam int PIN_LOAD   = 2;
    localparam int PIN_COMMIT = 3;
    localparam int NPIN       = 4;

    typedef struct packed {
        logic             rng;
        logic [DW_DEF-1:0] code;
    } chan_t;
endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
        logic [N-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o  = st_q.chain[STAGES-1];
    assign rise_o = ~st_q.prev & lvl_o;
    assign fall_o = st_q.prev & ~lvl_o;

    AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0)); // R3
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
    parameter int WW = 11
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          strobe_i,
    input  logic          gate_i,
    input  logic          bit_i,
    output logic [WW-1:0] word_o
);
    typedef struct packed {
        logic [WW-1:0] sr;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (strobe_i && gate_i) begin
            sh_d.sr = {sh_q.sr[WW-2:0], bit_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign word_o = sh_q.sr;

    AST_NO_SHIFT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(strobe_i && gate_i) |=> $stable(sh_q.sr)); // R3
    AST_SHIFT_LAST_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && gate_i) |=> (sh_q.sr[0] == $past(bit_i)
                                  && sh_q.sr[WW-1:1] == $past(sh_q.sr[WW-2:0]))); // R4
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int AW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int WW = AW + 1 + DW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WW-1:0]     word_i,
    input  logic              load_fall_i,
    input  logic              commit_lvl_i,
    input  logic              commit_fall_i,
    output logic [NCH*DW-1:0] code_o,
    output logic [NCH-1:0]    range_o
);
    typedef struct packed {
        logic          rng;
        logic [DW-1:0] code;
    } slot_t;

    typedef struct packed {
        slot_t [NCH-1:0] inl;
        slot_t [NCH-1:0] outl;
    } bank_t;

    bank_t bk_d, bk_q;

    logic [AW-1:0] sel;
    slot_t         fresh;

    assign sel        = word_i[WW-1 -: AW];
    assign fresh.rng  = word_i[DW];
    assign fresh.code = word_i[DW-1:0];

    always_comb begin
        bk_d = bk_q;
        if (commit_fall_i) begin
            bk_d.outl = bk_q.inl;
        end
        if (load_fall_i) begin
            for (int c = 0; c < NCH; c++) begin
                if (sel == AW'(c)) begin
                    bk_d.inl[c] = fresh;
                    if (!commit_lvl_i) bk_d.outl[c] = fresh;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bk_q <= '0;
        else         bk_q <= bk_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign code_o[g*DW +: DW] = bk_q.outl[g].code;
        assign range_o[g]         = bk_q.outl[g].rng;
    end

    AST_HOLD_STAGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_lvl_i && !commit_fall_i) |=> $stable(bk_q.outl)); // R6
    AST_COPY_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_fall_i && !load_fall_i) |=> (bk_q.outl == $past(bk_q.inl))); // R6
    AST_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_lvl_i |=> (bk_q.outl == bk_q.inl)); // R5
    AST_LOAD_ONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_fall_i |=> $stable(bk_q.inl)); // R2
endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend
    import qdac_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int DW  = DW_DEF
) (
    input  logic              sys_clk_i,
    input  logic              sys_rst_ni,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              ser_load_i,
    input  logic              commit_ni,
    output logic [NCH*DW-1:0] dac_code_o,
    output logic [NCH-1:0]    dac_range_o
);
    localparam int AW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WW = AW + 1 + DW;

    logic [NPIN-1:0] pins, lvl, rise, fall;
    logic [WW-1:0]   word;

    assign pins[PIN_SCLK]   = ser_clk_i;
    assign pins[PIN_SDATA]  = ser_data_i;
    assign pins[PIN_LOAD]   = ser_load_i;
    assign pins[PIN_COMMIT] = commit_ni;

    qdac_pin_sync #(.N(NPIN), .STAGES(2)) u_sync (
        .clk_i  (sys_clk_i),
        .rst_ni (sys_rst_ni),
        .pin_i  (pins),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    qdac_shift #(.WW(WW)) u_shift (
        .clk_i    (sys_clk_i),
        .rst_ni   (sys_rst_ni),
        .strobe_i (fall[PIN_SCLK]),
        .gate_i   (lvl[PIN_LOAD]),
        .bit_i    (lvl[PIN_SDATA]),
        .word_o   (word)
    );

    qdac_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk_i         (sys_clk_i),
        .rst_ni        (sys_rst_ni),
        .word_i        (word),
        .load_fall_i   (fall[PIN_LOAD]),
        .commit_lvl_i  (lvl[PIN_COMMIT]),
        .commit_fall_i (fall[PIN_COMMIT]),
        .code_o        (dac_code_o),
        .range_o       (dac_range_o)
    );

    logic unused_rise;
    assign unused_rise = ^rise;

    AST_RESET_ZERO: assert property (@(posedge sys_clk_i)
        !sys_rst_ni |=> (dac_code_o == '0 && dac_range_o == '0)); // R1
endmodule

// File: tb/qdac_frontend_tb.sv
module qdac_frontend_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_clk = 1'b0, s_dat = 1'b0, s_load = 1'b1, commit_n = 1'b0;
    logic [31:0] code;
    logic [3:0]  rng;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] exp_in_c[4], exp_out_c[4];
    logic       exp_in_r[4], exp_out_r[4];

    always #5 clk = ~clk;

    qdac_frontend u_dut (
        .sys_clk_i  (clk),
        .sys_rst_ni (rst_n),
        .ser_clk_i  (s_clk),
        .ser_data_i (s_dat),
        .ser_load_i (s_load),
        .commit_ni  (commit_n),
        .dac_code_o (code),
        .dac_range_o(rng)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int c = 0; c < 4; c++) begin
            chk(req, {24'd0, code[c*8 +: 8]}, {24'd0, exp_out_c[c]});
            chk(req, {31'd0, rng[c]}, {31'd0, exp_out_r[c]});
        end
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); s_dat = v[i];
            wait_cyc(3); s_clk = 1'b1;
            wait_cyc(3); s_clk = 1'b0;
            wait_cyc(3);
        end
    endtask

    task automatic model_load(input logic [1:0] a, input logic r, input logic [7:0] d);
        exp_in_c[a] = d; exp_in_r[a] = r;
        if (!commit_n) begin exp_out_c[a] = d; exp_out_r[a] = r; end
    endtask

    task automatic send(input logic [1:0] a, input logic r, input logic [7:0] d);
        @(negedge clk); s_load = 1'b1; wait_cyc(4);
        shift_bits({21'd0, a, r, d}, 11);
        s_load = 1'b0; wait_cyc(6);
        model_load(a, r, d);
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++) begin
            exp_in_c[c] = 0; exp_out_c[c] = 0; exp_in_r[c] = 0; exp_out_r[c] = 0;
        end
        rst_n = 1'b0; wait_cyc(5);
        chk_all("R1 during reset");
        rst_n = 1'b1; wait_cyc(8);
        chk_all("R1 after reset");
    endtask

    task automatic t_direct;
        commit_n = 1'b0; wait_cyc(6);
        send(2'd0, 1'b0, 8'h11); chk_all("R5 R2 ch0");
        send(2'd1, 1'b1, 8'hA2); chk_all("R7 R2 ch1");
        send(2'd2, 1'b0, 8'h80); chk_all("R2 ch2");
        send(2'd3, 1'b1, 8'hFF); chk_all("R7 R5 ch3");
        send(2'd1, 1'b0, 8'h01); chk_all("R7 range back to x1");
    endtask

    task automatic t_long;
        @(negedge clk); s_load = 1'b1; wait_cyc(4);
        shift_bits(32'h1B, 5);
        shift_bits({21'd0, 2'd3, 1'b0, 8'h5C}, 11);
        s_load = 1'b0; wait_cyc(6);
        model_load(2'd3, 1'b0, 8'h5C);
        chk_all("R4 last 11 bits");
    endtask

    task automatic t_gate;
        send(2'd2, 1'b0, 8'h3C); chk_all("R3 first load");
        shift_bits({21'd0, 2'd2, 1'b1, 8'hFF}, 11);
        @(negedge clk); s_load = 1'b1; wait_cyc(6);
        s_load = 1'b0; wait_cyc(6);
        chk_all("R3 clocks with load low ignored");
    endtask

    task automatic t_dbuf;
        @(negedge clk); commit_n = 1'b1; wait_cyc(6);
        send(2'd0, 1'b1, 8'h44);
        send(2'd1, 1'b1, 8'h55);
        send(2'd2, 1'b0, 8'h66);
        chk_all("R6 outputs hold while staged");
        @(negedge clk); commit_n = 1'b0; wait_cyc(6);
        for (int c = 0; c < 4; c++) begin
            exp_out_c[c] = exp_in_c[c]; exp_out_r[c] = exp_in_r[c];
        end
        chk_all("R6 commit copies all");
    endtask

    task automatic t_same;
        @(negedge clk); commit_n = 1'b1; wait_cyc(6);
        send(2'd3, 1'b1, 8'h9D);
        @(negedge clk); s_load = 1'b1; wait_cyc(4);
        shift_bits({21'd0, 2'd1, 1'b0, 8'h27}, 11);
        chk_all("R8 staged before joint edge");
        @(negedge clk); s_load = 1'b0; commit_n = 1'b0; wait_cyc(6);
        exp_in_c[1] = 8'h27; exp_in_r[1] = 1'b0;
        for (int c = 0; c < 4; c++) begin
            exp_out_c[c] = exp_in_c[c]; exp_out_r[c] = exp_in_r[c];
        end
        chk_all("R8 joint edges forward new word");
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_direct();
        t_long();
        t_gate();
        t_dbuf();
        t_same();
        wait_cyc(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule